// File: doc/BRIEF.md
# Rotating Secondary Bus Arbiter

This block decides which master may use the secondary side of a bus bridge. Up to six external masters, each with an active-low request line and an active-low grant line, compete with the bridge itself. Priority rotates so that every requester is served in turn. The arbiter watches the bus-idle status (FRAME and IRDY both high) to detect whether a granted master has started a transaction. Grants that go unused are revoked. Masters that the bridge has just retried can be held off for a programmed time. Whenever no one else needs the bus, the arbiter parks it on the bridge.

A strap input selects between two arrangements. In central mode the arbiter runs in full and parks on the bridge. With the strap low the arbiter stays out of the way: no external master receives a grant, and request line 0 becomes an incoming grant for the bridge from an arbiter outside the block. In both modes the bridge drives the idle bus only while it holds a grant.

Top module: `sec_bus_arbiter`

## Requirements
- R1: While reset is asserted, every external grant is high (inactive), `brg_gnt` is 0 and `park_drive` is 0.
- R2: Agents are numbered 0 (the bridge, `brg_req`) and 1..6 (`ext_req_n[0..5]`). When no grant is held, the next grant goes to the first eligible agent in cyclic order after the agent granted last. An eligible agent is requesting, not locked out and not masked. The agent granted last is 0 out of reset.
- R3: There is at least one clock with no grant at all between grants to two different agents. From a parked bridge with an external request pending, the external grant appears on the second clock.
- R4: An external master that holds its grant for 16 clocks of idle bus without starting a transaction loses the grant. The grant is therefore visible for exactly 16 clocks.
- R5: A master whose grant was revoked under R4 gets no grant until its request has been high for at least one clock edge. Once it requests again, the grant returns within a few clocks.
- R6: A granted master that pulls `frame_n` low has started a transaction. From then on it keeps its grant while it requests and no other agent is eligible, with no timeout.
- R7: In central mode, with no eligible requester, the grant parks on the bridge (`brg_gnt`=1). `park_drive` is high exactly while the bridge holds the grant and both `frame_n` and `irdy_n` are high.
- R8: With `central_en` low, no external grant is given. `brg_gnt` follows the inverse of `ext_req_n[0]` one clock later, and `park_drive` is high only while `brg_gnt` is 1 and the bus is idle.
- R9: A `retry_hit` pulse for master `retry_idx` with `mask_sel` of 1, 2 or 3 makes that master ineligible for 16, 32 or 64 clocks. A value of 0 disables the mask. With a parked bridge, a retry at edge E0 and a request raised just after E0, the grant appears after edge E0+2+L, where L is the mask length.
- R10: While the bridge holds the grant and `brg_req` is high, it keeps the bus until it has started a transaction (`frame_n` low). After that it yields to a pending master.
- R11: At most one grant is active at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Secondary bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| central_en | input | 1 | Strap: 1 = arbiter active and parks on bridge |
| ext_req_n | input | N_EXT | Active-low requests of external masters; bit 0 is the incoming bridge grant when the strap is low |
| brg_req | input | 1 | Bridge wants the secondary bus |
| frame_n | input | 1 | Bus FRAME, active low |
| irdy_n | input | 1 | Bus IRDY, active low |
| retry_hit | input | 1 | One-clock pulse: bridge retried a secondary master |
| retry_idx | input | RW | Index of the retried master |
| mask_sel | input | 2 | Retry mask length: 0 off, 1/2/3 = 16/32/64 clocks |
| ext_gnt_n | output | N_EXT | Active-low grants to external masters |
| brg_gnt | output | 1 | Bridge holds the grant |
| park_drive | output | 1 | Bridge should drive AD, C/BE and PAR on the idle bus |

## Verification
The bench covers all 63 request patterns of the six masters. It follows the rotation from pattern to pattern, so an arbiter that restarts priority at a fixed agent, or skips the dead clock, hands out a grant in the wrong order or in back-to-back clocks.

The idle timeout is checked to the exact clock. An off-by-one counter holds the grant for 15 or 17 clocks. A missing lockout re-grants the master at once, and a lockout that never clears starves the master for good.

Every mask setting is measured for every master by the arrival clock of the grant. A decoder that swaps settings, or a counter that stops early, shows up as a wrong count.

Tests of the strap mode and of the bridge hold catch an arbiter that still grants external masters when the strap is low. They also catch a bridge that gives up the bus before its own transaction.

// File: rtl/sarb_pkg.sv
package sarb_pkg;

  typedef enum logic [1:0] {
    MASK_OFF   = 2'd0,
    MASK_SHORT = 2'd1,
    MASK_MID   = 2'd2,
    MASK_LONG  = 2'd3
  } mask_sel_e;

  // Clock count that a retried master stays ineligible for each setting.
  function automatic int mask_len(input logic [1:0] sel, input int unit);
    case (mask_sel_e'(sel))
      MASK_SHORT: return unit;
      MASK_MID:   return 2 * unit;
      MASK_LONG:  return 4 * unit;
      default:    return 0;
    endcase
  endfunction

endpackage

// File: rtl/sarb_reqmask.sv
module sarb_reqmask #(
  parameter int N_EXT     = 6,
  parameter int MASK_UNIT = 16,
  localparam int NA = N_EXT + 1,
  localparam int IW = $clog2(NA),
  localparam int RW = (N_EXT > 1) ? $clog2(N_EXT) : 1,
  localparam int MW = $clog2(4 * MASK_UNIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] req_i,
  input  logic             retry_hit,
  input  logic [RW-1:0]    retry_idx,
  input  logic [1:0]       mask_sel,
  input  logic             to_fire,
  input  logic [IW-1:0]    to_idx,
  output logic [N_EXT-1:0] lock_o,
  output logic [N_EXT-1:0] mask_o,
  output logic [N_EXT-1:0] elig_o
);
  import sarb_pkg::*;

  for (genvar g = 0; g < N_EXT; g++) begin : g_master
    logic          lock_q;
    logic [MW-1:0] cnt_q;

    // Lockout after an unused grant; cleared by one clock of request high.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lock_q <= 1'b0;
      end else if (to_fire && to_idx == IW'(g + 1)) begin
        lock_q <= 1'b1;
      end else if (!req_i[g]) begin
        lock_q <= 1'b0;
      end
    end

    // Retry hold-off counter.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (retry_hit && retry_idx == RW'(g) && mask_sel != MASK_OFF) begin
        cnt_q <= MW'(mask_len(mask_sel, MASK_UNIT));
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end

    assign lock_o[g] = lock_q;
    assign mask_o[g] = (cnt_q != '0);
  end

  assign elig_o = req_i & ~lock_o & ~mask_o;

endmodule

// File: rtl/sarb_pick.sv
module sarb_pick #(
  parameter int NA = 7,
  localparam int IW = $clog2(NA)
) (
  input  logic [NA-1:0] elig_i,
  input  logic [IW-1:0] last_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o
);

  function automatic logic [IW-1:0] wrap(input logic [IW-1:0] base, input int off);
    int s;
    s = int'(base) + off;
    if (s >= NA) s = s - NA;
    return IW'(s);
  endfunction

  // Scan from farthest to nearest so the nearest eligible agent wins.
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int off = NA; off >= 1; off--) begin
      if (elig_i[wrap(last_i, off)]) begin
        vld_o = 1'b1;
        idx_o = wrap(last_i, off);
      end
    end
  end

endmodule

// File: rtl/sarb_grant.sv
module sarb_grant #(
  parameter int NA         = 7,
  parameter int IDLE_LIMIT = 16,
  localparam int IW = $clog2(NA),
  localparam int CW = $clog2(IDLE_LIMIT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          central_en,
  input  logic [NA-1:0] req_all,
  input  logic [NA-1:0] elig,
  input  logic          frame_n,
  input  logic          irdy_n,
  input  logic          ext_grant_in,
  input  logic          pick_vld,
  input  logic [IW-1:0] pick_idx,
  output logic [NA-1:0] gnt_o,
  output logic [IW-1:0] last_o,
  output logic          to_fire,
  output logic [IW-1:0] to_idx
);

  logic [NA-1:0] gnt_q, nxt_gnt;
  logic [IW-1:0] last_q, nxt_last, own_idx;
  logic [CW-1:0] cnt_q, nxt_cnt;
  logic          started_q, nxt_started;
  logic          bus_idle, others_pend, own_req;

  assign bus_idle    = frame_n & irdy_n;
  assign others_pend = |(elig & ~gnt_q);
  assign own_req     = |(req_all & gnt_q);

  always_comb begin
    own_idx = '0;
    for (int i = 0; i < NA; i++) begin
      if (gnt_q[i]) own_idx = IW'(i);
    end
  end

  always_comb begin
    nxt_gnt     = gnt_q;
    nxt_last    = last_q;
    nxt_cnt     = cnt_q;
    nxt_started = started_q;
    to_fire     = 1'b0;
    if (!central_en) begin
      // External arbitration: the bridge only follows the incoming grant.
      nxt_cnt     = '0;
      nxt_started = 1'b0;
      nxt_gnt     = '0;
      if (gnt_q[NA-1:1] == '0) nxt_gnt[0] = ext_grant_in;
    end else if (gnt_q == '0) begin
      nxt_cnt     = '0;
      nxt_started = 1'b0;
      nxt_gnt     = '0;
      if (pick_vld) begin
        nxt_gnt[pick_idx] = 1'b1;
        nxt_last          = pick_idx;
      end else begin
        nxt_gnt[0] = 1'b1;  // park on the bridge
      end
    end else if (gnt_q[0]) begin
      if (!frame_n) nxt_started = 1'b1;
      if (req_all[0]) nxt_last = '0;
      if (others_pend && (!req_all[0] || started_q)) nxt_gnt = '0;
    end else begin
      if (!own_req) begin
        nxt_gnt = '0;
      end else if (started_q) begin
        if (others_pend) nxt_gnt = '0;
      end else if (!frame_n) begin
        nxt_started = 1'b1;
      end else if (bus_idle) begin
        if (cnt_q == CW'(IDLE_LIMIT - 1)) begin
          nxt_gnt = '0;
          to_fire = 1'b1;
        end else begin
          nxt_cnt = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q     <= '0;
      last_q    <= '0;
      cnt_q     <= '0;
      started_q <= 1'b0;
    end else begin
      gnt_q     <= nxt_gnt;
      last_q    <= nxt_last;
      cnt_q     <= nxt_cnt;
      started_q <= nxt_started;
    end
  end

  assign gnt_o  = gnt_q;
  assign last_o = last_q;
  assign to_idx = own_idx;

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q)); // R11

  AST_DEAD_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q != '0 && $past(gnt_q) != '0) |-> (gnt_q == $past(gnt_q))); // R3

  AST_STRAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!central_en) |-> (gnt_q[NA-1:1] == '0)); // R8

endmodule

// File: rtl/sec_bus_arbiter.sv
module sec_bus_arbiter #(
  parameter int N_EXT      = 6,
  parameter int IDLE_LIMIT = 16,
  parameter int MASK_UNIT  = 16,
  localparam int NA = N_EXT + 1,
  localparam int IW = $clog2(NA),
  localparam int RW = (N_EXT > 1) ? $clog2(N_EXT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             central_en,
  input  logic [N_EXT-1:0] ext_req_n,
  input  logic             brg_req,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             retry_hit,
  input  logic [RW-1:0]    retry_idx,
  input  logic [1:0]       mask_sel,
  output logic [N_EXT-1:0] ext_gnt_n,
  output logic             brg_gnt,
  output logic             park_drive
);

  logic [N_EXT-1:0] ext_req, lock_v, mask_v, ext_elig;
  logic [NA-1:0]    elig_all, req_all, gnt_v;
  logic [IW-1:0]    last_idx, pick_idx, to_idx;
  logic             pick_vld, to_fire;

  assign ext_req  = ~ext_req_n;
  assign req_all  = {ext_req, brg_req};
  assign elig_all = {ext_elig, brg_req};

  sarb_reqmask #(.N_EXT(N_EXT), .MASK_UNIT(MASK_UNIT)) u_mask (
    .clk(clk), .rst_n(rst_n), .req_i(ext_req),
    .retry_hit(retry_hit), .retry_idx(retry_idx), .mask_sel(mask_sel),
    .to_fire(to_fire), .to_idx(to_idx),
    .lock_o(lock_v), .mask_o(mask_v), .elig_o(ext_elig)
  );

  sarb_pick #(.NA(NA)) u_pick (
    .elig_i(elig_all), .last_i(last_idx), .vld_o(pick_vld), .idx_o(pick_idx)
  );

  sarb_grant #(.NA(NA), .IDLE_LIMIT(IDLE_LIMIT)) u_grant (
    .clk(clk), .rst_n(rst_n), .central_en(central_en),
    .req_all(req_all), .elig(elig_all), .frame_n(frame_n), .irdy_n(irdy_n),
    .ext_grant_in(~ext_req_n[0]), .pick_vld(pick_vld), .pick_idx(pick_idx),
    .gnt_o(gnt_v), .last_o(last_idx), .to_fire(to_fire), .to_idx(to_idx)
  );

  assign ext_gnt_n  = ~gnt_v[NA-1:1];
  assign brg_gnt    = gnt_v[0];
  assign park_drive = gnt_v[0] & frame_n & irdy_n;

  for (genvar g = 0; g < N_EXT; g++) begin : g_chk
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gnt_v[g+1]) |-> $past(mask_v[g] == 1'b0)); // R9

    AST_LOCK_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      lock_v[g] |-> !gnt_v[g+1]); // R5
  end

endmodule

// File: tb/sim_sec_bus_arbiter.sv
`timescale 1ns/1ps
module sim_sec_bus_arbiter;
  localparam int NE = 6;

  logic          clk = 1'b0, rst_n = 1'b0, central_en = 1'b1;
  logic [NE-1:0] ext_req_n = '1;
  logic          brg_req = 1'b0, frame_n = 1'b1, irdy_n = 1'b1, retry_hit = 1'b0;
  logic [2:0]    retry_idx = '0;
  logic [1:0]    mask_sel = '0;
  logic [NE-1:0] ext_gnt_n;
  logic          brg_gnt, park_drive;

  int checks = 0, fails = 0, last_ag = 0;

  always #2.5 clk = ~clk;

  sec_bus_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .central_en(central_en), .ext_req_n(ext_req_n),
    .brg_req(brg_req), .frame_n(frame_n), .irdy_n(irdy_n), .retry_hit(retry_hit),
    .retry_idx(retry_idx), .mask_sel(mask_sel), .ext_gnt_n(ext_gnt_n),
    .brg_gnt(brg_gnt), .park_drive(park_drive)
  );

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int who();
    int r = -1;
    for (int i = 0; i < NE; i++) if (!ext_gnt_n[i]) r = i;
    return r;
  endfunction

  function automatic int nlow();
    int c = 0;
    for (int i = 0; i < NE; i++) if (!ext_gnt_n[i]) c++;
    return c;
  endfunction

  function automatic int model_next(input int last, input logic [NE-1:0] rem);
    for (int off = 1; off <= NE + 1; off++) begin
      int a = (last + off) % (NE + 1);
      if (a >= 1 && rem[a-1]) return a - 1;
    end
    return -1;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_grant(input int limit, output int g, output int n);
    g = -1;
    n = 0;
    while (g < 0 && n < limit) begin
      step();
      n++;
      g = who();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int g, n, held, expn;
    bit ok;
    logic [NE-1:0] rem;

    // R1: reset state
    repeat (3) step();
    chk(ext_gnt_n == '1 && !brg_gnt && !park_drive, "R1", "grants in reset",
        int'(ext_gnt_n), 63);
    rst_n = 1'b1;
    step();
    // R7: park on the bridge
    chk(brg_gnt && park_drive && ext_gnt_n == '1, "R7", "parked grant", int'(brg_gnt), 1);
    frame_n = 1'b0; #1;
    chk(!park_drive, "R7", "park drive with busy bus", int'(park_drive), 0);
    frame_n = 1'b1; #1;
    chk(park_drive, "R7", "park drive idle again", int'(park_drive), 1);

    // R2/R3/R11: every request pattern
    for (int p = 1; p < 64; p++) begin
      ext_req_n = ~NE'(p);
      rem = NE'(p);
      while (rem != '0) begin
        int e;
        e = model_next(last_ag, rem);
        wait_grant(8, g, n);
        chk(g == e, "R2", "rotation winner", g, e);
        chk(nlow() == 1 && !brg_gnt, "R11", "single grant", nlow(), 1);
        if (g < 0) break;
        last_ag = g + 1;
        ext_req_n[g] = 1'b1;
        rem[g] = 1'b0;
        step();
        chk(who() < 0 && !brg_gnt, "R3", "dead clock between grants", who(), -1);
      end
      ext_req_n = '1;
      step();
      step();
    end

    // R9: mask timer for every master and setting
    for (int k = 0; k < NE; k++) begin
      for (int s = 0; s < 4; s++) begin
        retry_idx = 3'(k);
        mask_sel = 2'(s);
        retry_hit = 1'b1;
        step();
        retry_hit = 1'b0;
        ext_req_n[k] = 1'b0;
        wait_grant(100, g, n);
        expn = 2 + ((s == 0) ? 0 : (16 << (s - 1)));
        chk(g == k, "R9", "masked master granted", g, k);
        chk(n == expn, "R9", "clocks until grant", n, expn);
        last_ag = k + 1;
        ext_req_n[k] = 1'b1;
        step();
        step();
      end
    end
    mask_sel = '0;

    // R4: unused grant revoked after 16 idle clocks
    ext_req_n[3] = 1'b0;
    wait_grant(8, g, n);
    chk(g == 3, "R4", "grant before timeout", g, 3);
    last_ag = 4;
    held = 1;
    while (held < 40) begin
      step();
      if (who() == 3) held++;
      else break;
    end
    chk(held == 16, "R4", "clocks of unused grant", held, 16);
    // R5: locked out while request stays low
    ok = 1'b1;
    repeat (30) begin
      step();
      if (who() == 3) ok = 1'b0;
    end
    chk(ok && brg_gnt, "R5", "no regrant while locked", int'(ok), 1);
    ext_req_n[3] = 1'b1;
    step();
    ext_req_n[3] = 1'b0;
    wait_grant(6, g, n);
    chk(g == 3, "R5", "regrant after request drop", g, 3);
    ext_req_n[3] = 1'b1;
    step();
    step();

    // R6: started transaction keeps the grant
    ext_req_n[1] = 1'b0;
    wait_grant(8, g, n);
    chk(g == 1, "R6", "grant before start", g, 1);
    last_ag = 2;
    frame_n = 1'b0;
    ok = 1'b1;
    repeat (30) begin
      step();
      if (who() != 1) ok = 1'b0;
    end
    chk(ok, "R6", "grant held past idle limit", int'(ok), 1);
    frame_n = 1'b1;
    ext_req_n[1] = 1'b1;
    step();
    step();

    // R10: bridge keeps bus until it starts
    brg_req = 1'b1;
    step();
    last_ag = 0;
    ext_req_n[1] = 1'b0;
    ok = 1'b1;
    repeat (10) begin
      step();
      if (!brg_gnt || who() >= 0) ok = 1'b0;
    end
    chk(ok, "R10", "bridge holds while requesting", int'(ok), 1);
    frame_n = 1'b0;
    step();
    frame_n = 1'b1;
    wait_grant(8, g, n);
    chk(g == 1, "R10", "master after bridge start", g, 1);
    brg_req = 1'b0;
    last_ag = 2;
    ext_req_n[1] = 1'b1;
    step();
    step();

    // R8: strap low, request 0 is an incoming grant
    central_en = 1'b0;
    ext_req_n = 6'b111010;
    step();
    step();
    chk(brg_gnt && who() < 0, "R8", "bridge follows incoming grant", who(), -1);
    chk(park_drive, "R8", "drive while granted and idle", int'(park_drive), 1);
    frame_n = 1'b0; #1;
    chk(!park_drive, "R8", "no drive on busy bus", int'(park_drive), 0);
    frame_n = 1'b1; #1;
    ext_req_n[0] = 1'b1;
    step();
    chk(!brg_gnt && !park_drive && who() < 0, "R8", "incoming grant removed",
        int'(brg_gnt), 0);
    ext_req_n = '1;
    central_en = 1'b1;
    step();
    step();
    chk(brg_gnt && park_drive, "R7", "park after strap returns", int'(brg_gnt), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule